// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is a register file whose 32 logical registers are seen through a movable window. A current-window index picks which slice of a larger physical array the logical numbers land on. Eight logical registers are common to every window. The other 24 split into three banks of eight: incoming, private and outgoing. The outgoing bank of one window is physically the incoming bank of the next window, so a caller leaves arguments in its outgoing registers and the callee finds them in its incoming registers without any copy.

The file has two combinational read ports and one write port that updates on the clock edge. Two command pins move the window. A call steps it forward and a return steps it back, both modulo the window count. An internal liveness mask records which windows hold active frames. A call into a window that is still live raises a one-cycle overflow flag. A return into a window that is not live raises a one-cycle underflow flag. In both trap cases the window index stays put. Saving windows to memory and restoring them is left to the surrounding logic. All pins are plain level signals with no handshake. No port carries a stream, so no port applies back-pressure.

Top module: `winreg_top`

## Requirements
- R1: After reset the window index is 0, both trap flags are low, and window 0 is the only live window, so a return issued straight after reset underflows.
- R2: Logical register 0 always reads as zero on both read ports, and a write to it has no effect.
- R3: Logical registers 1 to 7 map to the same physical registers in every window.
- R4: Outgoing register 8+k in window w is the same storage as incoming register 24+k in window (w+1) mod NWIN, including the wrap from the last window to window 0.
- R5: Private registers 16 to 23 are separate for each window. A value written in one window survives a call, a write of the same logical number in the callee, and the matching return.
- R6: A call that does not trap sets the window index to (index+1) mod NWIN and marks that window live. A return that does not trap clears the current window's live bit and sets the index to (index-1) mod NWIN.
- R7: A call whose target window is live sets the overflow flag high for exactly the next cycle and leaves the index unchanged.
- R8: A return whose target window is not live sets the underflow flag high for exactly the next cycle and leaves the index unchanged.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible after the clock edge.
- R10: When call and return are asserted in the same cycle, only the call is acted on.
- R11: A write issued in the same cycle as a call or return is mapped through the window index held before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Logical register number for read port A |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Logical register number for read port B |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number to write |
| wr_data | input | XLEN | Write data |
| call_i | input | 1 | Step the window forward |
| ret_i | input | 1 | Step the window back |
| cwp_o | output | CWPW | Current window index |
| ovf_trap_o | output | 1 | One-cycle overflow flag |
| unf_trap_o | output | 1 | One-cycle underflow flag |

## Verification
The bench builds the file with NWIN set to 4 and XLEN left at 64. With four windows, three calls fill every window. That brings the overflow trap and the wrap of the last window's outgoing bank onto window 0's incoming bank within a few cycles. Underflow is reached by returning from window 0 right after reset and again after unwinding the call chain. A simultaneous write and call shows whether the write is mapped through the old window index or the new one.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int GRP   = 8;   // registers per bank
  localparam int LREGS = 32;  // logical registers per window

  // Physical layout: globals at 0..7, then per window a block of 16
  // (incoming bank at offset 0, private bank at offset 8).
  function automatic int map_phys(input int lreg, input int win, input int nwin);
    int nxt;
    nxt = (win + 1) % nwin;
    if (lreg < GRP)          return lreg;
    else if (lreg < 2 * GRP) return GRP + 2 * GRP * nxt + (lreg - GRP);
    else if (lreg < 3 * GRP) return GRP + 2 * GRP * win + GRP + (lreg - 2 * GRP);
    else                     return GRP + 2 * GRP * win + (lreg - 3 * GRP);
  endfunction
endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
  parameter int NWIN = 8,
  parameter int PW   = 8,
  parameter int CWPW = 3
) (
  input  logic [4:0]      lreg,
  input  logic [CWPW-1:0] win,
  output logic [PW-1:0]   phys
);
  always_comb phys = PW'(winreg_pkg::map_phys(int'(lreg), int'(win), NWIN));
endmodule

// File: rtl/winreg_array.sv
module winreg_array #(
  parameter int XLEN  = 64,
  parameter int NPHYS = 136,
  parameter int PW    = 8
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [PW-1:0]   ra,
  input  logic [PW-1:0]   rb,
  output logic [XLEN-1:0] qa,
  output logic [XLEN-1:0] qb
);
  logic [XLEN-1:0] mem [NPHYS];

  // physical 0 is logical 0 in every window: never written, reads zero
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  always_comb begin
    qa = (ra == '0) ? '0 : mem[ra];
    qb = (rb == '0) ? '0 : mem[rb];
  end
endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
  parameter int NWIN = 8,
  parameter int CWPW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  output logic [CWPW-1:0] cwp,
  output logic            ovf,
  output logic            unf
);
  logic [NWIN-1:0] live_q;
  logic [CWPW-1:0] nxt_w, prv_w;

  always_comb begin
    nxt_w = (cwp == CWPW'(NWIN - 1)) ? '0 : cwp + 1'b1;
    prv_w = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp    <= '0;
      live_q <= NWIN'(1);
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (call_i) begin
        if (live_q[nxt_w]) ovf <= 1'b1;
        else begin
          live_q[nxt_w] <= 1'b1;
          cwp           <= nxt_w;
        end
      end else if (ret_i) begin
        if (!live_q[prv_w]) unf <= 1'b1;
        else begin
          live_q[cwp] <= 1'b0;
          cwp         <= prv_w;
        end
      end
    end
  end
endmodule

// File: rtl/winreg_top.sv
module winreg_top #(
  parameter int NWIN = 8,   // 2..32
  parameter int XLEN = 64,
  localparam int NPHYS = 8 + 16 * NWIN,
  localparam int PW    = $clog2(NPHYS),
  localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            call_i,
  input  logic            ret_i,
  output logic [CWPW-1:0] cwp_o,
  output logic            ovf_trap_o,
  output logic            unf_trap_o
);
  localparam int NPORT = 3;  // read A, read B, write

  logic [4:0]    lidx [NPORT];
  logic [PW-1:0] pidx [NPORT];
  logic [CWPW-1:0] cwp;

  assign lidx[0] = rd_a_idx;
  assign lidx[1] = rd_b_idx;
  assign lidx[2] = wr_idx;

  winreg_ctrl #(.NWIN(NWIN), .CWPW(CWPW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .cwp(cwp), .ovf(ovf_trap_o), .unf(unf_trap_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    winreg_map #(.NWIN(NWIN), .PW(PW), .CWPW(CWPW)) u_map (
      .lreg(lidx[p]), .win(cwp), .phys(pidx[p])
    );
  end

  winreg_array #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW)) u_arr (
    .clk(clk), .we(wr_en), .wa(pidx[2]), .wd(wr_data),
    .ra(pidx[0]), .rb(pidx[1]), .qa(rd_a_data), .qb(rd_b_data)
  );

  assign cwp_o = cwp;
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 64,
  parameter int CWPW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [4:0]      rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            call_i,
  input logic            ret_i,
  input logic [CWPW-1:0] cwp_o,
  input logic            ovf_trap_o,
  input logic            unf_trap_o
);
  function automatic logic [CWPW-1:0] step_up(input logic [CWPW-1:0] c);
    return (c == CWPW'(NWIN - 1)) ? '0 : c + 1'b1;
  endfunction
  function automatic logic [CWPW-1:0] step_dn(input logic [CWPW-1:0] c);
    return (c == '0) ? CWPW'(NWIN - 1) : c - 1'b1;
  endfunction

  assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0 && (rd_b_idx != 5'd0 || rd_b_data == '0)));

  assert_call_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> (ovf_trap_o ? cwp_o == $past(cwp_o) : cwp_o == step_up($past(cwp_o))));

  assert_ret_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> (unf_trap_o ? cwp_o == $past(cwp_o) : cwp_o == step_dn($past(cwp_o))));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_i && !ret_i) |=> ($stable(cwp_o) && !ovf_trap_o && !unf_trap_o));

  assert_call_no_unf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> !unf_trap_o);

  assert_trap_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap_o, unf_trap_o}));
endmodule

bind winreg_top winreg_chk #(.NWIN(NWIN), .XLEN(XLEN), .CWPW(CWPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .call_i(call_i), .ret_i(ret_i),
  .cwp_o(cwp_o), .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o)
);

// File: tb/tb_winreg_top.sv
module tb_winreg_top;
  localparam int CLK_PERIOD = 20;
  localparam int NWIN = 4;
  localparam int XLEN = 64;
  localparam int CWPW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [CWPW-1:0] cwp_o;
  logic ovf_trap_o, unf_trap_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int kind; logic [XLEN-1:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  winreg_top #(.NWIN(NWIN), .XLEN(XLEN)) dut (.*);

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      begin
        item_t it;
        logic [XLEN-1:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = rd_a_data;
          1: act = rd_b_data;
          2: act = XLEN'(cwp_o);
          3: act = XLEN'(ovf_trap_o);
          default: act = XLEN'(unf_trap_o);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [XLEN-1:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic rd_a(input logic [4:0] idx, input logic [XLEN-1:0] exp, input string tag);
    @(negedge clk); rd_a_idx = idx; push(0, exp, tag);
  endtask

  task automatic rd_b(input logic [4:0] idx, input logic [XLEN-1:0] exp, input string tag);
    @(negedge clk); rd_b_idx = idx; push(1, exp, tag);
  endtask

  task automatic wr(input logic [4:0] idx, input logic [XLEN-1:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // issue command; afterwards check window index and both trap flags
  task automatic cmd(input bit c, input bit r, input int exp_cwp,
                     input bit exp_o, input bit exp_u, input string tag);
    @(negedge clk); call_i = c; ret_i = r;
    @(negedge clk); call_i = 0; ret_i = 0;
    push(2, XLEN'(exp_cwp), tag);
    push(3, XLEN'(exp_o), tag);
    push(4, XLEN'(exp_u), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    push(2, 0, "R1 cwp after reset");
    push(3, 0, "R1 ovf after reset");
    push(4, 0, "R1 unf after reset");
    // R8 / R1: return with only window 0 live underflows
    cmd(0, 1, 0, 0, 1, "R8 underflow at reset");
    @(negedge clk); push(4, 0, "R8 underflow lasts one cycle");
    // R2
    wr(5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_a(5'd0, 0, "R2 r0 port A zero");
    rd_b(5'd0, 0, "R2 r0 port B zero");
    // setup window 0
    wr(5'd5, 64'hA5A5);
    wr(5'd9, 64'h1111);
    wr(5'd17, 64'h2222);
    wr(5'd25, 64'h3333);
    // R9 read during write returns old value
    wr(5'd20, 64'hAAAA);
    @(negedge clk); wr_en = 1; wr_idx = 5'd20; wr_data = 64'hBBBB; rd_a_idx = 5'd20;
    push(0, 64'hAAAA, "R9 old value during write");
    @(negedge clk); wr_en = 0; push(0, 64'hBBBB, "R9 new value after edge");
    // R6 call to window 1
    cmd(1, 0, 1, 0, 0, "R6 call 0->1");
    rd_a(5'd25, 64'h1111, "R4 caller out1 is callee in1");
    rd_b(5'd5, 64'hA5A5, "R3 global in window 1");
    wr(5'd17, 64'h4444);
    cmd(1, 0, 2, 0, 0, "R6 call 1->2");
    cmd(1, 0, 3, 0, 0, "R6 call 2->3");
    rd_b(5'd5, 64'hA5A5, "R3 global in window 3");
    wr(5'd12, 64'h5555);
    // R7 overflow: window 0 still live
    cmd(1, 0, 3, 1, 0, "R7 overflow from last window");
    @(negedge clk); push(3, 0, "R7 overflow lasts one cycle");
    // R10 call and return together: call wins
    cmd(1, 1, 3, 1, 0, "R10 call wins over return");
    cmd(0, 1, 2, 0, 0, "R6 return 3->2");
    cmd(0, 1, 1, 0, 0, "R6 return 2->1");
    rd_a(5'd17, 64'h4444, "R5 local of window 1");
    cmd(0, 1, 0, 0, 0, "R6 return 1->0");
    rd_a(5'd17, 64'h2222, "R5 local of window 0 preserved");
    rd_a(5'd28, 64'h5555, "R4 wrap out4 of last window is in4 of window 0");
    rd_b(5'd25, 64'h3333, "R4 window 0 in1 unchanged");
    // R11 write together with call uses old window
    @(negedge clk); wr_en = 1; wr_idx = 5'd9; wr_data = 64'h7777; call_i = 1;
    @(negedge clk); wr_en = 0; call_i = 0;
    push(2, 1, "R11 call taken");
    rd_a(5'd25, 64'h7777, "R11 write mapped through old window");
    cmd(0, 1, 0, 0, 0, "R6 return 1->0 again");
    cmd(0, 1, 0, 0, 1, "R8 underflow after unwinding");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule